// File: doc/BRIEF.md
# Configurable Macrocell Register Cell

This block is one storage cell of a small programmable-logic fabric. A product-term array (outside the block) hands it a combinational sum-of-products value plus a second product term. Configuration inputs then decide how the cell stores that value. It can act as a D, T, JK or SR flip-flop, or the register can be bypassed so the sum-of-products goes straight out. The selected result drives both the pin-side output and the feedback into the global routing.

The fabric is emulated inside a faster host clock domain. Every clock source of the cell is an ordinary signal, and the cell samples it on the host clock. A low-to-high change of the selected source is a storage edge. The source is one of two global clock lines, each built from either global clock pin, true or inverted. It may instead be a product-term clock. A product-term enable can gate the global edge. Product-term preset and clear act at once, without waiting for a host edge. A global active-low clear can be routed to the cell by a per-cell setting.

Top module: `mcell_reg_cell`

## Requirements
- R1: While `rstN` is low the stored value is 0. The edge detector starts as if the selected source were already high, so a source that is high when reset ends gives no edge until it has gone low.
- R2: With `cfgFfKind`=0 (D), a storage edge loads `sopIn`.
- R3: With `cfgFfKind`=1 (T), a storage edge inverts the stored value when `sopIn`=1 and keeps it when `sopIn`=0.
- R4: With `cfgFfKind`=2 (JK, J=`sopIn`, K=`auxIn`), a storage edge gives: 00 hold, 01 load 0, 10 load 1, 11 invert.
- R5: With `cfgFfKind`=3 (SR, S=`sopIn`, R=`auxIn`), a storage edge gives: 00 hold, 01 load 0, 10 load 1, 11 hold.
- R6: A storage edge is a host cycle in which the selected source is 1 and was 0 at the previous host edge. `cfgClkMode` picks the source: 0 a global line alone; 1 a global line, counted only while `ptEna`=1; 2 `ptClk`; 3 behaves as 0. Without a storage edge the stored value holds.
- R7: Global line i takes pin `gclkPin[cfgLineSrc[i]]` and XORs it with `cfgLineInv[i]`. `cfgLineSel` picks the line used by the cell.
- R8: `ptSet`=1 forces the stored value to 1 and `ptClr`=1 forces it to 0, both without a host edge. When both are high, clear wins. While either is high, storage edges have no effect.
- R9: When `cfgUseGclr`=1, `gClrN`=0 clears the cell like `ptClr`. When `cfgUseGclr`=0, `gClrN` has no effect.
- R10: With `cfgBypass`=1, `cellOut` follows `sopIn` combinationally. `cellOut` and `fbOut` are always equal, and both show the stored value when `cfgBypass`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock that samples all fabric clock sources |
| rstN | input | 1 | Host reset, active low |
| sopIn | input | 1 | Sum-of-products data (D, T, J or S) |
| auxIn | input | 1 | Second product term (K or R) |
| ptClk | input | 1 | Product-term clock |
| ptEna | input | 1 | Product-term clock enable, active high |
| ptSet | input | 1 | Product-term asynchronous preset, active high |
| ptClr | input | 1 | Product-term asynchronous clear, active high |
| gclkPin | input | NUM_PINS | Global clock pins |
| gClrN | input | 1 | Global clear pin, active low |
| cfgFfKind | input | 2 | Flip-flop type: 0 D, 1 T, 2 JK, 3 SR |
| cfgClkMode | input | 2 | Clock source mode |
| cfgLineSel | input | LINE_IDX_W | Global line used by this cell |
| cfgLineSrc | input | NUM_LINES*PIN_IDX_W | Pin index per global line |
| cfgLineInv | input | NUM_LINES | Inversion per global line |
| cfgUseGclr | input | 1 | Route the global clear to this cell |
| cfgBypass | input | 1 | Bypass the register |
| cellOut | output | 1 | Output toward the pin logic |
| fbOut | output | 1 | Feedback toward the global routing |

## Verification
The hardest situations to reach are the ones where control inputs overlap: preset and clear together, a storage edge during a clear, and a global line switched or inverted while its pin is already high. Any of these can give an unintended edge or a wrong winner. The stimulus puts the selected line in a known low state before it reprograms the line settings. It raises the asynchronous inputs between host edges, checks the output two nanoseconds later, and pulses clocks while a clear is still held. A behavioural model runs in step with the cell and catches any stray edge on the very next cycle.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [1:0] {
    FF_D  = 2'd0,
    FF_T  = 2'd1,
    FF_JK = 2'd2,
    FF_SR = 2'd3
  } ffKind_e;

  typedef enum logic [1:0] {
    CK_GLOBAL    = 2'd0,
    CK_GLOBAL_EN = 2'd1,
    CK_PTERM     = 2'd2,
    CK_RSVD      = 2'd3
  } clkMode_e;

  // strobes from the clock/control side to the storage side
  typedef struct packed {
    logic tick;      // qualified storage edge this host cycle
    logic setAsync;  // merged asynchronous preset
    logic clrAsync;  // merged asynchronous clear
  } cellStrobe_t;

endpackage

// File: rtl/mcell_clk_ctrl.sv
module mcell_clk_ctrl
  import mcell_pkg::*;
#(
  parameter int NUM_PINS  = 2,
  parameter int NUM_LINES = 2,
  localparam int PIN_IDX_W  = (NUM_PINS  > 1) ? $clog2(NUM_PINS)  : 1,
  localparam int LINE_IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           ptClk,
  input  logic                           ptEna,
  input  logic                           ptSet,
  input  logic                           ptClr,
  input  logic [NUM_PINS-1:0]            gclkPin,
  input  logic                           gClrN,
  input  clkMode_e                       clkMode,
  input  logic [LINE_IDX_W-1:0]          cfgLineSel,
  input  logic [NUM_LINES*PIN_IDX_W-1:0] cfgLineSrc,
  input  logic [NUM_LINES-1:0]           cfgLineInv,
  input  logic                           cfgUseGclr,
  output cellStrobe_t                    strobe
);

  logic [NUM_LINES-1:0] lineVal;
  logic selClk;
  logic prevClk;
  logic rise;

  // each global line: one pin, optionally inverted
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [PIN_IDX_W-1:0] srcIdx;
    assign srcIdx     = cfgLineSrc[i*PIN_IDX_W +: PIN_IDX_W];
    assign lineVal[i] = gclkPin[srcIdx] ^ cfgLineInv[i];
  end

  always_comb begin
    case (clkMode)
      CK_PTERM: selClk = ptClk;
      default:  selClk = lineVal[cfgLineSel];
    endcase
  end

  // primed high so a source already high at reset exit is not an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevClk <= 1'b1;
    else       prevClk <= selClk;
  end

  assign rise = selClk & ~prevClk;

  always_comb begin
    strobe.tick     = rise & ((clkMode != CK_GLOBAL_EN) | ptEna);
    strobe.setAsync = ptSet;
    strobe.clrAsync = ptClr | (cfgUseGclr & ~gClrN);
  end

  // R6: an edge detector never reports two storage edges back to back
  a_r6_single_tick: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |=> !strobe.tick);

endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sopIn,
  input  logic        auxIn,
  input  ffKind_e     ffKind,
  input  logic        cfgBypass,
  input  cellStrobe_t strobe,
  output logic        cellOut,
  output logic        fbOut
);

  logic stateQ;
  logic nextQ;
  logic clrA;
  logic setA;
  logic clrAny;
  logic selOut;

  assign clrA   = strobe.clrAsync;
  assign setA   = strobe.setAsync;
  assign clrAny = ~rstN | clrA;

  always_comb begin
    case (ffKind)
      FF_D:  nextQ = sopIn;
      FF_T:  nextQ = stateQ ^ sopIn;
      FF_JK: begin
        case ({sopIn, auxIn})
          2'b00:   nextQ = stateQ;
          2'b01:   nextQ = 1'b0;
          2'b10:   nextQ = 1'b1;
          default: nextQ = ~stateQ;
        endcase
      end
      default: begin
        case ({sopIn, auxIn})
          2'b01:   nextQ = 1'b0;
          2'b10:   nextQ = 1'b1;
          default: nextQ = stateQ;
        endcase
      end
    endcase
  end

  // clear (and host reset) over preset over clocked update
  always_ff @(posedge clk or posedge clrAny or posedge setA) begin
    if (clrAny)           stateQ <= 1'b0;
    else if (setA)        stateQ <= 1'b1;
    else if (strobe.tick) stateQ <= nextQ;
  end

  // one selected source feeds both destinations
  assign selOut  = cfgBypass ? sopIn : stateQ;
  assign cellOut = selOut;
  assign fbOut   = selOut;

  a_r2_d_capture: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !clrA && !setA && ffKind == FF_D)
      |=> (stateQ == $past(sopIn)) || clrA || setA);

  a_r3_t_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !clrA && !setA && ffKind == FF_T && !sopIn)
      |=> $stable(stateQ) || clrA || setA);

  a_r4_jk_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !clrA && !setA && ffKind == FF_JK && sopIn && auxIn)
      |=> (stateQ != $past(stateQ)) || clrA || setA);

  a_r5_sr_both_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !clrA && !setA && ffKind == FF_SR && sopIn && auxIn)
      |=> $stable(stateQ) || clrA || setA);

  a_r6_hold_no_edge: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !clrA && !setA) |=> $stable(stateQ) || clrA || setA);

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(clrA) && clrA) |-> !stateQ);

  a_r8_preset_holds: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(setA && !clrA) && setA && !clrA) |-> stateQ);

endmodule

// File: rtl/mcell_reg_cell.sv
module mcell_reg_cell
  import mcell_pkg::*;
#(
  parameter int NUM_PINS  = 2,
  parameter int NUM_LINES = 2,
  localparam int PIN_IDX_W  = (NUM_PINS  > 1) ? $clog2(NUM_PINS)  : 1,
  localparam int LINE_IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           sopIn,
  input  logic                           auxIn,
  input  logic                           ptClk,
  input  logic                           ptEna,
  input  logic                           ptSet,
  input  logic                           ptClr,
  input  logic [NUM_PINS-1:0]            gclkPin,
  input  logic                           gClrN,
  input  logic [1:0]                     cfgFfKind,
  input  logic [1:0]                     cfgClkMode,
  input  logic [LINE_IDX_W-1:0]          cfgLineSel,
  input  logic [NUM_LINES*PIN_IDX_W-1:0] cfgLineSrc,
  input  logic [NUM_LINES-1:0]           cfgLineInv,
  input  logic                           cfgUseGclr,
  input  logic                           cfgBypass,
  output logic                           cellOut,
  output logic                           fbOut
);

  cellStrobe_t strobe;

  mcell_clk_ctrl #(
    .NUM_PINS  (NUM_PINS),
    .NUM_LINES (NUM_LINES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ptClk      (ptClk),
    .ptEna      (ptEna),
    .ptSet      (ptSet),
    .ptClr      (ptClr),
    .gclkPin    (gclkPin),
    .gClrN      (gClrN),
    .clkMode    (clkMode_e'(cfgClkMode)),
    .cfgLineSel (cfgLineSel),
    .cfgLineSrc (cfgLineSrc),
    .cfgLineInv (cfgLineInv),
    .cfgUseGclr (cfgUseGclr),
    .strobe     (strobe)
  );

  mcell_store u_store (
    .clk       (clk),
    .rstN      (rstN),
    .sopIn     (sopIn),
    .auxIn     (auxIn),
    .ffKind    (ffKind_e'(cfgFfKind)),
    .cfgBypass (cfgBypass),
    .strobe    (strobe),
    .cellOut   (cellOut),
    .fbOut     (fbOut)
  );

endmodule

// File: tb/mcell_reg_cell_bench.sv
`timescale 1ns/1ps
module mcell_reg_cell_bench;

  logic clk = 1'b0;
  logic rstN;
  logic sopIn, auxIn, ptClk, ptEna, ptSet, ptClr, gClrN;
  logic [1:0] gclkPin;
  logic [1:0] cfgFfKind, cfgClkMode;
  logic       cfgLineSel;
  logic [1:0] cfgLineSrc, cfgLineInv;
  logic       cfgUseGclr, cfgBypass;
  logic       cellOut, fbOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  mcell_reg_cell u_mcell_reg_cell (
    .clk(clk), .rstN(rstN), .sopIn(sopIn), .auxIn(auxIn), .ptClk(ptClk),
    .ptEna(ptEna), .ptSet(ptSet), .ptClr(ptClr), .gclkPin(gclkPin),
    .gClrN(gClrN), .cfgFfKind(cfgFfKind), .cfgClkMode(cfgClkMode),
    .cfgLineSel(cfgLineSel), .cfgLineSrc(cfgLineSrc), .cfgLineInv(cfgLineInv),
    .cfgUseGclr(cfgUseGclr), .cfgBypass(cfgBypass),
    .cellOut(cellOut), .fbOut(fbOut)
  );

  // behavioural reference, advanced on each host edge
  bit mq, mprev, srcNow, edgeNow, clrNow, nxt;
  always @(posedge clk) begin
    if (!rstN) begin
      mq = 0; mprev = 1;
    end else begin
      if (cfgClkMode == 2) srcNow = ptClk;
      else srcNow = gclkPin[cfgLineSrc[cfgLineSel]] ^ cfgLineInv[cfgLineSel];
      edgeNow = srcNow && !mprev;
      mprev = srcNow;
      clrNow = ptClr || (cfgUseGclr && !gClrN);
      case (cfgFfKind)
        0: nxt = sopIn;
        1: nxt = sopIn ? !mq : mq;
        2: nxt = (sopIn && auxIn) ? !mq : (sopIn ? 1 : (auxIn ? 0 : mq));
        default: nxt = (sopIn && !auxIn) ? 1 : ((!sopIn && auxIn) ? 0 : mq);
      endcase
      if (clrNow) mq = 0;
      else if (ptSet) mq = 1;
      else if (edgeNow && (cfgClkMode != 1 || ptEna)) mq = nxt;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, sampled at the falling edge
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(curReq, cellOut, cfgBypass ? sopIn : mq);
      chk("R10", fbOut, cellOut);
    end
  endtask

  task automatic gpulse(input int pin);
    gclkPin[pin] = 1'b1; cyc(1);
    gclkPin[pin] = 1'b0; cyc(1);
  endtask

  task automatic ppulse();
    ptClk = 1'b1; cyc(1);
    ptClk = 1'b0; cyc(1);
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rstN = 0; sopIn = 0; auxIn = 0; ptClk = 0; ptEna = 0; ptSet = 0; ptClr = 0;
    gClrN = 1; gclkPin = 2'b00; cfgFfKind = 0; cfgClkMode = 0; cfgLineSel = 0;
    cfgLineSrc = 2'b10; cfgLineInv = 2'b00; cfgUseGclr = 0; cfgBypass = 0;
    repeat (3) @(negedge clk);
    chk("R1", cellOut, 1'b0);
    rstN = 1;
    cyc(2);
    chk("R1", cellOut, 1'b0);

    // R2 D type
    curReq = "R2";
    sopIn = 1; gpulse(0); chk("R2", cellOut, 1'b1);
    sopIn = 0; gpulse(0); chk("R2", cellOut, 1'b0);
    sopIn = 1; cyc(3);    chk("R6", cellOut, 1'b0);

    // R3 T type
    curReq = "R3"; cfgFfKind = 1;
    sopIn = 1; gpulse(0); chk("R3", cellOut, 1'b1);
    gpulse(0);            chk("R3", cellOut, 1'b0);
    gpulse(0);            chk("R3", cellOut, 1'b1);
    sopIn = 0; gpulse(0); chk("R3", cellOut, 1'b1);

    // R4 JK type
    curReq = "R4"; cfgFfKind = 2;
    sopIn = 0; auxIn = 1; gpulse(0); chk("R4", cellOut, 1'b0);
    sopIn = 1; auxIn = 0; gpulse(0); chk("R4", cellOut, 1'b1);
    sopIn = 1; auxIn = 1; gpulse(0); chk("R4", cellOut, 1'b0);
    gpulse(0);                       chk("R4", cellOut, 1'b1);
    sopIn = 0; auxIn = 0; gpulse(0); chk("R4", cellOut, 1'b1);

    // R5 SR type
    curReq = "R5"; cfgFfKind = 3;
    sopIn = 1; auxIn = 1; gpulse(0); chk("R5", cellOut, 1'b1);
    sopIn = 0; auxIn = 1; gpulse(0); chk("R5", cellOut, 1'b0);
    sopIn = 1; auxIn = 1; gpulse(0); chk("R5", cellOut, 1'b0);
    sopIn = 1; auxIn = 0; gpulse(0); chk("R5", cellOut, 1'b1);
    sopIn = 0; auxIn = 0; gpulse(0); chk("R5", cellOut, 1'b1);

    // R6 clock modes
    curReq = "R6"; cfgFfKind = 0; auxIn = 0;
    cfgClkMode = 1; ptEna = 0; sopIn = 0;
    gpulse(0); chk("R6", cellOut, 1'b1);
    ptEna = 1; gpulse(0); chk("R6", cellOut, 1'b0);
    cfgClkMode = 2; sopIn = 1;
    gpulse(0); gpulse(1); chk("R6", cellOut, 1'b0);
    ppulse();  chk("R6", cellOut, 1'b1);
    cfgClkMode = 3; sopIn = 0;
    ppulse();  chk("R6", cellOut, 1'b1);
    gpulse(0); chk("R6", cellOut, 1'b0);

    // R7 global lines: line1 = inverted pin1, then remapped to pin0
    curReq = "R7"; cfgClkMode = 0; sopIn = 1;
    gclkPin[1] = 1; cyc(1);
    cfgLineSel = 1; cfgLineInv = 2'b10; cyc(2);
    chk("R7", cellOut, 1'b0);
    gclkPin[1] = 0; cyc(1); chk("R7", cellOut, 1'b1);
    sopIn = 0;
    gclkPin[1] = 1; cyc(1); chk("R7", cellOut, 1'b1);
    gclkPin[1] = 0; cyc(1); chk("R7", cellOut, 1'b0);
    cfgLineSrc = 2'b00; cyc(1);
    sopIn = 1;
    gclkPin[0] = 1; cyc(1); chk("R7", cellOut, 1'b0);
    gclkPin[0] = 0; cyc(1); chk("R7", cellOut, 1'b1);
    cfgLineSel = 0; cfgLineInv = 2'b00; cfgLineSrc = 2'b10; cyc(2);

    // R8 asynchronous preset and clear
    curReq = "R8"; sopIn = 0; gpulse(0); chk("R8", cellOut, 1'b0);
    ptSet = 1; #2; chk("R8", cellOut, 1'b1);
    cyc(1);
    ptClr = 1; #2; chk("R8", cellOut, 1'b0);
    cyc(1);
    sopIn = 1; gpulse(0); chk("R8", cellOut, 1'b0);
    ptClr = 0; cyc(1); chk("R8", cellOut, 1'b1);
    ptSet = 0; cyc(1); chk("R8", cellOut, 1'b1);

    // R9 global clear routing
    curReq = "R9";
    gClrN = 0; cyc(2); chk("R9", cellOut, 1'b1);
    cfgUseGclr = 1; #2; chk("R9", cellOut, 1'b0);
    cyc(1);
    gClrN = 1; gpulse(0); chk("R9", cellOut, 1'b1);
    gClrN = 0; ptSet = 1; #2; chk("R9", cellOut, 1'b0);
    cyc(1);
    gClrN = 1; ptSet = 0; cfgUseGclr = 0; cyc(2);

    // R10 bypass
    curReq = "R10"; cfgBypass = 1;
    sopIn = 0; #2; chk("R10", cellOut, 1'b0); chk("R10", fbOut, 1'b0);
    sopIn = 1; #2; chk("R10", cellOut, 1'b1); chk("R10", fbOut, 1'b1);
    ptClr = 1; #2; chk("R10", cellOut, 1'b1);
    cyc(1);
    ptClr = 0; cfgBypass = 0; #2; chk("R10", cellOut, 1'b0);
    cyc(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule